// File: doc/BRIEF.md
# Time-Aware Priority Gate Sequencer

This block drives the transmit gates of one Ethernet port. It has eight priorities and one gate bit for each. A command memory holds gate-control words. Each word carries a duration, counted in wire-side clock ticks, and an allow mask that applies for that duration. When a duration runs out, the sequencer moves to the next word. A zero duration ends the list.

An external generator supplies a pulse at the start of every schedule period. Each pulse restarts the list from its first entry.

The memory works in one of two modes:
- **Single-bank mode.** All 128 words form one long list.
- **Split mode.** The memory forms two 64-word halves. One half runs as the live schedule. Software writes a replacement schedule into the other half. It then raises a ready pulse. The two halves exchange roles at the next period start.

Time synchronisation, frame transmission and the conversion of durations into tick counts are all handled outside this block.

Top module: `tas_gate_seq`

## Requirements
- R1: While reset is held, and on the clock after `enable` is sampled low, `gateMask` is all ones, `entryIdx` is 0 and `running` is 0. Reset also clears `adminPending` and sets `activeBank` to 0. After re-enabling, the mask stays all ones until a period start.
- R2: A command word stores the tick count in bits [21:8] and the allow mask in bits [7:0]. Mask bit i high opens the gate of priority i.
- R3: When `cycleStart` is sampled high with `enable` high, entry 0's mask appears on `gateMask` after that same edge. Each command's mask then stays for exactly its count of clocks.
- R4: When a command's count runs out, the next entry's mask and index appear on the following clock. The index never moves by more than one except on a restart.
- R5: Reaching an entry whose count is zero ends the list. `running` drops, and `gateMask` and `entryIdx` keep the last executed command's values until the next period start.
- R6: If entry 0 of the list is zero when a period starts, `running` stays 0, `entryIdx` becomes 0, and `gateMask` keeps its previous value.
- R7: A `cycleStart` that arrives while a list is still running restarts it at entry 0.
- R8: In split mode, each write stores `wrData` at index `wrAddr[5:0]` of the bank that is not active. Such a write leaves the live schedule unchanged.
- R9: An `adminReady` pulse sets `adminPending`. At the next enabled period start in split mode, `activeBank` toggles and `adminPending` clears.
- R10: A period start with no pending admin schedule keeps the same active bank.
- R11: In split mode, index 63 is the last entry of a bank, so a list that fills a whole bank ends there and never runs into the other bank. In single-bank mode, the list continues past index 63 into index 64.
- R12: In single-bank mode, each write stores `wrData` at index `wrAddr`. An enabled period start clears `adminPending` without changing `activeBank`.
- R13: The full count of 16383 holds a mask for exactly 16383 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wire-side clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Sequencer enable; when low, all gates are open |
| splitMode | input | 1 | 1 selects two 64-entry banks, 0 selects one 128-entry bank |
| wrEn | input | 1 | Command memory write strobe |
| wrAddr | input | 7 | Write index (bank-relative in split mode) |
| wrData | input | 22 | Command word: count [21:8], mask [7:0] |
| adminReady | input | 1 | Pulse that marks the inactive bank as ready |
| cycleStart | input | 1 | Period-start pulse from the external generator |
| gateMask | output | 8 | Registered per-priority gate mask |
| entryIdx | output | 7 | Index of the command currently applied |
| running | output | 1 | High while a list is being executed |
| activeBank | output | 1 | Bank that holds the live schedule |
| adminPending | output | 1 | Admin schedule waiting for a period start |

## Verification
The assertions check the following on every clock:
- the all-open state after `enable` is seen low;
- index 0 after a period start;
- index movement of at most one step;
- frozen mask and index while the sequencer is idle;
- bank toggles only at a period start with a pending admin schedule;
- `adminPending` clearing at a consumed period start.

The directed scenarios cover what a property cannot show:
- the exact length of each command, up to the full 16383-tick count;
- the list ending at the bank boundary in split mode and continuing past it in single-bank mode;
- writes landing in the inactive bank and leaving the live schedule intact.

// File: rtl/tas_gate_pkg.sv
package tas_gate_pkg;

  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic holdOpen;   // force gates open and index to 0
    logic restart;    // jump to entry 0 of the (possibly new) active bank
    logic swap;       // toggle the active bank with the restart
    logic step;       // move to the following entry
    logic loadMask;   // capture the selected entry's mask
  } seqCtl_t;

endpackage

// File: rtl/tas_gate_dp.sv
module tas_gate_dp
  import tas_gate_pkg::*;
#(
  parameter int NumPrio = 8,
  parameter int CountW  = 14,
  parameter int Depth   = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     splitMode,
  input  logic                     wrEn,
  input  logic [$clog2(Depth)-1:0] wrAddr,
  input  logic [CountW+NumPrio-1:0] wrData,
  input  seqCtl_t                  ctl,
  output logic [NumPrio-1:0]       gateMask,
  output logic [$clog2(Depth)-1:0] entryIdx,
  output logic                     activeBank,
  output logic [CountW-1:0]        headCurCount,
  output logic [CountW-1:0]        headAltCount,
  output logic [CountW-1:0]        nextCount,
  output logic                     lastInBank
);

  localparam int WordW = CountW + NumPrio;
  localparam int IdxW  = $clog2(Depth);
  localparam int HalfW = IdxW - 1;

  logic [WordW-1:0] cmdMem [Depth];

  logic [IdxW-1:0]  curBase;
  logic [IdxW-1:0]  altBase;
  logic [IdxW-1:0]  nextAddr;
  logic [IdxW-1:0]  wrPhys;
  logic [WordW-1:0] headCurWord;
  logic [WordW-1:0] headAltWord;
  logic [WordW-1:0] nextWord;

  // Bank base addresses: in single-bank mode both views start at 0.
  always_comb begin
    if (splitMode) begin
      curBase = {activeBank, {HalfW{1'b0}}};
      altBase = {~activeBank, {HalfW{1'b0}}};
      wrPhys  = {~activeBank, wrAddr[HalfW-1:0]};
    end else begin
      curBase = '0;
      altBase = '0;
      wrPhys  = wrAddr;
    end
  end

  assign nextAddr    = curBase + entryIdx + IdxW'(1);
  assign headCurWord = cmdMem[curBase];
  assign headAltWord = cmdMem[altBase];
  assign nextWord    = cmdMem[nextAddr];

  assign headCurCount = headCurWord[WordW-1:NumPrio];
  assign headAltCount = headAltWord[WordW-1:NumPrio];
  assign nextCount    = nextWord[WordW-1:NumPrio];

  // Last entry of the current list space depends on the bank mode.
  assign lastInBank = splitMode ? (&entryIdx[HalfW-1:0]) : (&entryIdx);

  // Command storage.
  always_ff @(posedge clk) begin
    if (wrEn) cmdMem[wrPhys] <= wrData;
  end

  // Registered gate mask, entry index and bank selection.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateMask   <= '1;
      entryIdx   <= '0;
      activeBank <= 1'b0;
    end else if (ctl.holdOpen) begin
      gateMask <= '1;
      entryIdx <= '0;
    end else if (ctl.restart) begin
      entryIdx <= '0;
      if (ctl.swap) activeBank <= ~activeBank;
      if (ctl.loadMask)
        gateMask <= ctl.swap ? headAltWord[NumPrio-1:0] : headCurWord[NumPrio-1:0];
    end else if (ctl.step) begin
      entryIdx <= entryIdx + IdxW'(1);
      if (ctl.loadMask) gateMask <= nextWord[NumPrio-1:0];
    end
  end

endmodule

// File: rtl/tas_gate_ctl.sv
module tas_gate_ctl
  import tas_gate_pkg::*;
#(
  parameter int CountW = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              splitMode,
  input  logic              cycleStart,
  input  logic              adminReady,
  input  logic [CountW-1:0] headCurCount,
  input  logic [CountW-1:0] headAltCount,
  input  logic [CountW-1:0] nextCount,
  input  logic              lastInBank,
  output seqCtl_t           ctl,
  output logic              running,
  output logic              adminPending
);

  logic [CountW-1:0] remaining;
  logic [CountW-1:0] startCount;
  logic              swapNow;
  logic              cmdDone;
  logic              canStep;

  assign swapNow    = adminPending & splitMode;
  assign startCount = swapNow ? headAltCount : headCurCount;
  assign cmdDone    = running && (remaining <= CountW'(1));
  assign canStep    = !lastInBank && (nextCount != '0);

  always_comb begin
    ctl = '0;
    if (!enable) begin
      ctl.holdOpen = 1'b1;
    end else if (cycleStart) begin
      ctl.restart  = 1'b1;
      ctl.swap     = swapNow;
      ctl.loadMask = (startCount != '0);
    end else if (cmdDone && canStep) begin
      ctl.step     = 1'b1;
      ctl.loadMask = 1'b1;
    end
  end

  // Admin hand-over flag.
  always_ff @(posedge clk) begin
    if (!rstN)
      adminPending <= 1'b0;
    else if (adminReady)
      adminPending <= 1'b1;
    else if (enable && cycleStart)
      adminPending <= 1'b0;
  end

  // Tick counter for the command currently applied.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      remaining <= '0;
    end else if (!enable) begin
      running   <= 1'b0;
      remaining <= '0;
    end else if (cycleStart) begin
      running   <= (startCount != '0);
      remaining <= startCount;
    end else if (running) begin
      if (!cmdDone)
        remaining <= remaining - CountW'(1);
      else if (canStep)
        remaining <= nextCount;
      else
        running <= 1'b0;
    end
  end

endmodule

// File: rtl/tas_gate_seq.sv
module tas_gate_seq
  import tas_gate_pkg::*;
#(
  parameter int NumPrio = 8,
  parameter int CountW  = 14,
  parameter int Depth   = 128
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      enable,
  input  logic                      splitMode,
  input  logic                      wrEn,
  input  logic [$clog2(Depth)-1:0]  wrAddr,
  input  logic [CountW+NumPrio-1:0] wrData,
  input  logic                      adminReady,
  input  logic                      cycleStart,
  output logic [NumPrio-1:0]        gateMask,
  output logic [$clog2(Depth)-1:0]  entryIdx,
  output logic                      running,
  output logic                      activeBank,
  output logic                      adminPending
);

  seqCtl_t           ctl;
  logic [CountW-1:0] headCurCount;
  logic [CountW-1:0] headAltCount;
  logic [CountW-1:0] nextCount;
  logic              lastInBank;

  tas_gate_ctl #(.CountW(CountW)) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .splitMode(splitMode),
    .cycleStart(cycleStart), .adminReady(adminReady),
    .headCurCount(headCurCount), .headAltCount(headAltCount),
    .nextCount(nextCount), .lastInBank(lastInBank),
    .ctl(ctl), .running(running), .adminPending(adminPending)
  );

  tas_gate_dp #(.NumPrio(NumPrio), .CountW(CountW), .Depth(Depth)) u_dp (
    .clk(clk), .rstN(rstN), .splitMode(splitMode),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .ctl(ctl),
    .gateMask(gateMask), .entryIdx(entryIdx), .activeBank(activeBank),
    .headCurCount(headCurCount), .headAltCount(headAltCount),
    .nextCount(nextCount), .lastInBank(lastInBank)
  );

endmodule

// File: rtl/tas_gate_seq_checker.sv
module tas_gate_seq_checker #(
  parameter int NumPrio = 8,
  parameter int IdxW    = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               splitMode,
  input logic               adminReady,
  input logic               cycleStart,
  input logic [NumPrio-1:0] gateMask,
  input logic [IdxW-1:0]    entryIdx,
  input logic               running,
  input logic               activeBank,
  input logic               adminPending
);

  // R1: disabled means all gates open, index 0, not running
  a_r1_disabled_open: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (gateMask == '1) && (entryIdx == '0) && !running);

  // R7: a period start always lands on entry 0
  a_r7_restart_idx: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cycleStart) |=> (entryIdx == '0));

  // R4: index advances one entry at a time
  a_r4_idx_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !cycleStart) |=>
      (entryIdx == $past(entryIdx)) || (entryIdx == IdxW'($past(entryIdx) + 1)));

  // R5: an idle sequencer keeps mask and index frozen
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !running && !cycleStart) |=> ($stable(gateMask) && $stable(entryIdx)));

  // R9: bank toggles only at a period start with a pending admin schedule
  a_r9_swap_at_start: assert property (@(posedge clk) disable iff (!rstN)
    (activeBank != $past(activeBank)) |->
      $past(cycleStart && enable && adminPending && splitMode));

  // R9: a consumed period start clears the pending flag
  a_r9_pending_clears: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cycleStart && !adminReady) |=> !adminPending);

endmodule

bind tas_gate_seq tas_gate_seq_checker #(
  .NumPrio(NumPrio), .IdxW($clog2(Depth))
) u_checker (
  .clk(clk), .rstN(rstN), .enable(enable), .splitMode(splitMode),
  .adminReady(adminReady), .cycleStart(cycleStart), .gateMask(gateMask),
  .entryIdx(entryIdx), .running(running), .activeBank(activeBank),
  .adminPending(adminPending)
);

// File: tb/tas_gate_seq_bench.sv
module tas_gate_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        splitMode = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  wrAddr = '0;
  logic [21:0] wrData = '0;
  logic        adminReady = 1'b0;
  logic        cycleStart = 1'b0;
  logic [7:0]  gateMask;
  logic [6:0]  entryIdx;
  logic        running;
  logic        activeBank;
  logic        adminPending;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tas_gate_seq u_tas_gate_seq (
    .clk(clk), .rstN(rstN), .enable(enable), .splitMode(splitMode),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .adminReady(adminReady),
    .cycleStart(cycleStart), .gateMask(gateMask), .entryIdx(entryIdx),
    .running(running), .activeBank(activeBank), .adminPending(adminPending)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic checkState(input string req, input int m, input int idx, input int run);
    check(req, "gateMask", int'(gateMask), m);
    check(req, "entryIdx", int'(entryIdx), idx);
    check(req, "running", int'(running), run);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCmd(input int addr, input int count, input int mask);
    wrEn   = 1'b1;
    wrAddr = 7'(addr);
    wrData = {14'(count), 8'(mask)};
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseStart();
    cycleStart = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
  endtask

  task automatic pulseAdmin();
    adminReady = 1'b1;
    @(negedge clk);
    adminReady = 1'b0;
  endtask

  // R1: reset state
  task automatic testReset();
    checkState("R1", 8'hFF, 0, 0);
    check("R1", "adminPending", int'(adminPending), 0);
    check("R1", "activeBank", int'(activeBank), 0);
  endtask

  // R2 R3 R4 R5 R7: single-bank list timing and restart
  task automatic testSequence();
    writeCmd(0, 3, 8'h01);
    writeCmd(1, 2, 8'h02);
    writeCmd(2, 4, 8'h04);
    writeCmd(3, 0, 8'hEE);
    enable = 1'b1;
    waitCycles(2);
    check("R1", "mask open after enable", int'(gateMask), 8'hFF);
    pulseStart();
    checkState("R3", 8'h01, 0, 1);
    waitCycles(2);
    check("R3", "mask end of cmd0", int'(gateMask), 8'h01);
    waitCycles(1);
    checkState("R4", 8'h02, 1, 1);
    waitCycles(2);
    checkState("R2", 8'h04, 2, 1);
    waitCycles(3);
    checkState("R3", 8'h04, 2, 1);
    waitCycles(1);
    checkState("R5", 8'h04, 2, 0);
    waitCycles(4);
    checkState("R5", 8'h04, 2, 0);
    pulseStart();
    waitCycles(4);
    check("R7", "mask before restart", int'(gateMask), 8'h02);
    pulseStart();
    checkState("R7", 8'h01, 0, 1);
    waitCycles(12);
  endtask

  // R8 R9 R10: ping-pong banks
  task automatic testBanks();
    splitMode = 1'b1;
    writeCmd(0, 2, 8'h80);
    writeCmd(1, 0, 8'h00);
    pulseAdmin();
    check("R9", "pending set", int'(adminPending), 1);
    check("R9", "bank before start", int'(activeBank), 0);
    pulseStart();
    check("R9", "bank swapped", int'(activeBank), 1);
    check("R9", "pending cleared", int'(adminPending), 0);
    checkState("R9", 8'h80, 0, 1);
    waitCycles(2);
    checkState("R5", 8'h80, 0, 0);
    pulseStart();
    check("R10", "bank kept", int'(activeBank), 1);
    check("R10", "mask", int'(gateMask), 8'h80);
    waitCycles(3);
    writeCmd(0, 5, 8'h55);
    writeCmd(1, 0, 8'h00);
    pulseStart();
    check("R8", "live bank untouched", int'(gateMask), 8'h80);
    waitCycles(3);
    pulseAdmin();
    pulseStart();
    check("R8", "new bank live", int'(activeBank), 0);
    checkState("R8", 8'h55, 0, 1);
    waitCycles(4);
    check("R8", "running t4", int'(running), 1);
    waitCycles(1);
    checkState("R5", 8'h55, 0, 0);
  endtask

  // R11: full bank ends at index 63 in split mode
  task automatic testBankEnd();
    for (int i = 0; i < 64; i++) writeCmd(i, 1, i);
    pulseAdmin();
    pulseStart();
    check("R11", "bank", int'(activeBank), 1);
    checkState("R11", 8'h00, 0, 1);
    waitCycles(63);
    checkState("R11", 63, 63, 1);
    waitCycles(1);
    checkState("R11", 63, 63, 0);
  endtask

  // R11 R12: single-bank list crosses index 63
  task automatic testSingleSpan();
    splitMode = 1'b0;
    for (int i = 0; i < 64; i++) writeCmd(i, 1, 8'hC0 | (i & 8'h3F));
    writeCmd(64, 2, 8'hA5);
    writeCmd(65, 0, 8'h00);
    pulseAdmin();
    check("R12", "pending set", int'(adminPending), 1);
    pulseStart();
    check("R12", "pending cleared", int'(adminPending), 0);
    check("R12", "bank unchanged", int'(activeBank), 1);
    check("R12", "mask entry0", int'(gateMask), 8'hC0);
    waitCycles(63);
    checkState("R11", 8'hFF, 63, 1);
    waitCycles(1);
    checkState("R11", 8'hA5, 64, 1);
    waitCycles(1);
    check("R11", "cmd64 held", int'(gateMask), 8'hA5);
    waitCycles(1);
    checkState("R11", 8'hA5, 64, 0);
  endtask

  // R6: empty list at period start
  task automatic testEmpty();
    writeCmd(0, 0, 8'h3C);
    pulseStart();
    checkState("R6", 8'hA5, 0, 0);
    waitCycles(3);
    checkState("R6", 8'hA5, 0, 0);
  endtask

  // R13: full-width count
  task automatic testMaxCount();
    writeCmd(0, 16383, 8'h11);
    writeCmd(1, 1, 8'h22);
    writeCmd(2, 0, 8'h00);
    pulseStart();
    check("R13", "mask start", int'(gateMask), 8'h11);
    waitCycles(16382);
    checkState("R13", 8'h11, 0, 1);
    waitCycles(1);
    checkState("R13", 8'h22, 1, 1);
    waitCycles(1);
    checkState("R13", 8'h22, 1, 0);
  endtask

  // R1: disable mid-run, re-enable
  task automatic testDisable();
    pulseStart();
    waitCycles(2);
    enable = 1'b0;
    waitCycles(1);
    checkState("R1", 8'hFF, 0, 0);
    enable = 1'b1;
    waitCycles(3);
    checkState("R1", 8'hFF, 0, 0);
    pulseStart();
    checkState("R1", 8'h11, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSequence();
    testBanks();
    testBankEnd();
    testSingleSpan();
    testEmpty();
    testMaxCount();
    testDisable();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule